// File: doc/BRIEF.md
# Always-On Real-Time Clock with Committed Register Writes

This block is a memory-mapped real-time clock for an always-on power domain. It keeps a 64-bit time value made of a 32-bit seconds word and a 32-bit sub-second word. A 64-bit alarm is compared against that time. Alongside these sit a control register, a status register and an interrupt-enable register, all reached over a 32-bit register bus. The sub-second word advances on a tick-enable input. When it wraps, the seconds word advances.

Register writes do not land at once, because the storage is modelled as a slow domain. The block takes each write into a single pending slot and marks itself busy. It applies the write a fixed number of cycles later and then reports completion. A write that arrives while the slot is occupied is thrown away and raises an error flag. Software polls the status word, or waits for the interrupt, to learn that a write has finished.

The request side has a valid strobe and no ready: every request is taken in the cycle it is presented, so there is no back-pressure. A read answers in the next cycle with a response-valid pulse, and that response cannot be stalled. A write that would need to wait is instead dropped and reported through the error flag. At power-on the block raises an invalid flag, which software clears. It keeps time only after software has written the seconds word at least once and set the run bit.

Top module: `rtc_keeper`

## Requirements
- R1: After reset the status word reads 0x202 (bit 9 ready-for-next, bit 1 invalid). Seconds and sub-second words read 0, both alarm words read 0xFFFFFFFF, control and interrupt-enable read 0, and the interrupt output is low.
- R2: Word index 0 is seconds, 1 sub-second, 2 alarm high, 3 alarm low, 4 control, 5 status, 6 interrupt-enable, and index 7 reads 0. A read presented with `req_valid` at a clock edge returns, one edge later, the register contents as they stood before that edge, with `rsp_valid` high.
- R3: A write taken while not busy sets status bit 10 (busy) and clears bit 9 (ready-for-next) and bit 8 (complete). Exactly WR_LAT=4 edges after the accepting edge, the target register takes the value, bit 10 clears, and bits 9 and 8 set. Until that point the target keeps its old value.
- R4: A write presented while busy is dropped: the target register does not change, and status bit 7 (error) sets.
- R5: A committed write to the status word clears, for each 1 in the written data, bit 7, 4, 1 or 0. Status bits 10, 9 and 8 are not changed by such writes.
- R6: The time value stays frozen unless control bit 3 (run) is set and the seconds word has been written at least once since reset. A write to the sub-second word alone does not start it.
- R7: While running, each cycle with `tick_en` high adds 1 to the sub-second word. When the sub-second word wraps from 0xFFFFFFFF to 0, the seconds word adds 1. A committed write to the sub-second word loads the written value.
- R8: Status bit 4 (alarm) sets when {seconds, sub-second} equals {alarm high, alarm low}, unless alarm high is 0xFFFFFFFF, which disables the match.
- R9: A cycle with `sec_viol` high sets status bit 0 (violation). Bits 0 and 1 are cleared only by a status write (R5).
- R10: `irq` is high exactly when some interrupt-enable bit among 9, 8, 7 and 4 is set together with the same status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_valid | input | 1 | Bus request strobe, always accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_idx | input | 3 | Register word index |
| req_wdata | input | 32 | Write data |
| tick_en | input | 1 | Sub-second advance strobe |
| sec_viol | input | 1 | Security violation event |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, OR of enabled status flags |

## Verification
On every cycle, the assertions check the following. The pending slot never stays busy longer than the commit latency and holds its contents while waiting. A commit always leaves the complete flag set, and a write refused while busy always raises the error flag. The time value cannot move before the seconds word is first written, and a sub-second wrap carries into the seconds word. The invalid flag never rises after reset, and an all-ones alarm high word never raises the alarm flag. Some behaviour only the directed scenarios can show: the exact cycle at which a written value becomes visible on a read, the decoding of each word index, the write-one-to-clear outcome for particular bit patterns, and the interrupt output following each enable bit.

// File: rtl/rtc_keeper_pkg.sv
package rtc_keeper_pkg;

  // Word indices on the register bus
  localparam logic [2:0] IDX_SEC    = 3'd0;
  localparam logic [2:0] IDX_FRAC   = 3'd1;
  localparam logic [2:0] IDX_ALM_HI = 3'd2;
  localparam logic [2:0] IDX_ALM_LO = 3'd3;
  localparam logic [2:0] IDX_CTRL   = 3'd4;
  localparam logic [2:0] IDX_STAT   = 3'd5;
  localparam logic [2:0] IDX_IEN    = 3'd6;

  // Status bit positions
  localparam int unsigned ST_BUSY    = 10;
  localparam int unsigned ST_NEXT    = 9;
  localparam int unsigned ST_DONE    = 8;
  localparam int unsigned ST_ERR     = 7;
  localparam int unsigned ST_ALARM   = 4;
  localparam int unsigned ST_INVALID = 1;
  localparam int unsigned ST_VIOL    = 0;

  // Control bit position
  localparam int unsigned CTRL_RUN = 3;

  // Flags a status write may clear: {err, alarm, invalid, viol}
  typedef struct packed {
    logic err;
    logic alarm;
    logic invalid;
    logic viol;
  } clr_mask_t;

endpackage

// File: rtl/rtc_wr_pipe.sv
module rtc_wr_pipe #(
  parameter int unsigned DW  = 32,
  parameter int unsigned LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [2:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          accept,
  output logic          drop,
  output logic          commit,
  output logic [2:0]    slot_idx,
  output logic [DW-1:0] slot_data
);
  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt_q;

  assign accept = wr_req && !busy;
  assign drop   = wr_req && busy;
  assign commit = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      slot_idx  <= '0;
      slot_data <= '0;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (wr_req) begin
      busy      <= 1'b1;
      cnt_q     <= CW'(LAT - 1);
      slot_idx  <= wr_idx;
      slot_data <= wr_data;
    end
  end

  // Checker: length of the current busy run
  logic [CW+1:0] busy_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else           busy_run_q <= '0;
  end

  // R3: a pending write commits within the fixed latency
  p_busy_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run_q <= (CW+2)'(LAT));

  // R3: the pending slot holds still until it commits
  p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> ($stable(slot_idx) && $stable(slot_data)));

endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
  import rtc_keeper_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      commit,
  input  logic      drop,
  input  clr_mask_t clr,
  input  logic      alarm_hit,
  input  logic      sec_viol,
  output logic      done,
  output logic      err,
  output logic      alarm,
  output logic      invalid,
  output logic      viol
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      err     <= 1'b0;
      alarm   <= 1'b0;
      invalid <= 1'b1;
      viol    <= 1'b0;
    end else begin
      if (commit)      done <= 1'b1;
      else if (accept) done <= 1'b0;

      if (drop)         err <= 1'b1;
      else if (clr.err) err <= 1'b0;

      if (alarm_hit)      alarm <= 1'b1;
      else if (clr.alarm) alarm <= 1'b0;

      if (clr.invalid) invalid <= 1'b0;

      if (sec_viol)      viol <= 1'b1;
      else if (clr.viol) viol <= 1'b0;
    end
  end

  // R9: the invalid flag is never raised again after reset
  p_invalid_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(invalid));

  // R3: every commit leaves the complete flag set
  p_done_after_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> done);

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_keeper_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          tick,
  input  logic          commit,
  input  logic [2:0]    idx,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] sec,
  output logic [DW-1:0] frac,
  output logic [DW-1:0] alm_hi,
  output logic [DW-1:0] alm_lo,
  output logic          hit
);

  logic seeded_q;
  logic running;
  logic step;
  logic wrap;

  assign running = run_en && seeded_q;
  assign step    = tick && running;
  assign wrap    = step && (frac == '1);
  assign hit     = (alm_hi != '1) && (sec == alm_hi) && (frac == alm_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec      <= '0;
      frac     <= '0;
      alm_hi   <= '1;
      alm_lo   <= '1;
      seeded_q <= 1'b0;
    end else begin
      if (commit && idx == IDX_SEC) begin
        sec      <= data;
        seeded_q <= 1'b1;
      end else if (wrap) begin
        sec <= sec + DW'(1);
      end

      if (commit && idx == IDX_FRAC) frac <= data;
      else if (step)                 frac <= frac + DW'(1);

      if (commit && idx == IDX_ALM_HI) alm_hi <= data;
      if (commit && idx == IDX_ALM_LO) alm_lo <= data;
    end
  end

  // R6: time cannot move before the seconds word is first written
  p_frozen_unseeded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seeded_q && !commit) |=> ($stable(sec) && $stable(frac)));

  // R7: a sub-second wrap carries into the seconds word
  p_wrap_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !commit) |=> ((sec == $past(sec) + DW'(1)) && (frac == '0)));

endmodule

// File: rtl/rtc_keeper.sv
module rtc_keeper
  import rtc_keeper_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned WR_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_idx,
  input  logic [DW-1:0] req_wdata,
  input  logic          tick_en,
  input  logic          sec_viol,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          irq
);
  localparam logic [DW-1:0] IEN_MASK  = DW'((1 << ST_NEXT) | (1 << ST_DONE) |
                                            (1 << ST_ERR) | (1 << ST_ALARM));
  localparam logic [DW-1:0] CTRL_MASK = DW'(1 << CTRL_RUN);

  logic          busy, accept, drop, commit;
  logic [2:0]    slot_idx;
  logic [DW-1:0] slot_data;
  logic          f_done, f_err, f_alarm, f_invalid, f_viol;
  logic [DW-1:0] sec, frac, alm_hi, alm_lo;
  logic          hit;
  logic [DW-1:0] ctrl_q, ien_q, stat_word, rd_mux;
  clr_mask_t     clr;

  rtc_wr_pipe #(.DW(DW), .LAT(WR_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .wr_req(req_valid && req_write), .wr_idx(req_idx), .wr_data(req_wdata),
    .busy(busy), .accept(accept), .drop(drop), .commit(commit),
    .slot_idx(slot_idx), .slot_data(slot_data)
  );

  always_comb begin
    clr = '0;
    if (commit && slot_idx == IDX_STAT) begin
      clr.err     = slot_data[ST_ERR];
      clr.alarm   = slot_data[ST_ALARM];
      clr.invalid = slot_data[ST_INVALID];
      clr.viol    = slot_data[ST_VIOL];
    end
  end

  rtc_status_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .commit(commit), .drop(drop), .clr(clr),
    .alarm_hit(hit), .sec_viol(sec_viol),
    .done(f_done), .err(f_err), .alarm(f_alarm),
    .invalid(f_invalid), .viol(f_viol)
  );

  rtc_time_core #(.DW(DW)) u_time (
    .clk(clk), .rst_n(rst_n),
    .run_en(ctrl_q[CTRL_RUN]), .tick(tick_en),
    .commit(commit), .idx(slot_idx), .data(slot_data),
    .sec(sec), .frac(frac), .alm_hi(alm_hi), .alm_lo(alm_lo), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else if (commit) begin
      if (slot_idx == IDX_CTRL) ctrl_q <= slot_data & CTRL_MASK;
      if (slot_idx == IDX_IEN)  ien_q  <= slot_data & IEN_MASK;
    end
  end

  always_comb begin
    stat_word             = '0;
    stat_word[ST_BUSY]    = busy;
    stat_word[ST_NEXT]    = !busy;
    stat_word[ST_DONE]    = f_done;
    stat_word[ST_ERR]     = f_err;
    stat_word[ST_ALARM]   = f_alarm;
    stat_word[ST_INVALID] = f_invalid;
    stat_word[ST_VIOL]    = f_viol;
  end

  assign irq = |(stat_word & ien_q);

  always_comb begin
    case (req_idx)
      IDX_SEC:    rd_mux = sec;
      IDX_FRAC:   rd_mux = frac;
      IDX_ALM_HI: rd_mux = alm_hi;
      IDX_ALM_LO: rd_mux = alm_lo;
      IDX_CTRL:   rd_mux = ctrl_q;
      IDX_STAT:   rd_mux = stat_word;
      IDX_IEN:    rd_mux = ien_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  // R4: a write refused while busy raises the error flag
  p_drop_sets_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && busy) |=> f_err);

  // R8: an all-ones alarm high word never raises the alarm flag
  p_alarm_unset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_hi == '1 && !f_alarm) |=> !f_alarm);

endmodule

// File: tb/rtc_keeper_tb.sv
module rtc_keeper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic        tick_en = 1'b0, sec_viol = 1'b0;
  logic        rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  rtc_keeper u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .tick_en(tick_en),
    .sec_viol(sec_viol), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_idx = idx; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_wait(logic [2:0] idx, logic [31:0] d);
    wr(idx, d);
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic rd(logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_idx = idx;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (rsp_valid !== 1'b1) begin
      checks++; failures++;
      $display("FAIL R2 rsp_valid actual=%b expected=1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); #1; tick_en = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd5, v); chk("R1 status", v, 32'h202);
    rd(3'd0, v); chk("R1 seconds", v, 0);
    rd(3'd1, v); chk("R1 subsec", v, 0);
    rd(3'd2, v); chk("R1 alarm hi", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R1 alarm lo", v, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R1 control", v, 0);
    rd(3'd6, v); chk("R1 irq enable", v, 0);
    rd(3'd7, v); chk("R2 index 7", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_handshake();
    logic [31:0] v;
    wr(3'd3, 32'h1234);
    for (int i = 0; i < 3; i++) begin
      rd(3'd5, v); chk("R3 busy window", v & 32'h700, 32'h400);
    end
    rd(3'd3, v); chk("R3 value held before commit", v, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R3 after commit", v & 32'h700, 32'h300);
    rd(3'd3, v); chk("R2 R3 alarm lo committed", v, 32'h1234);
  endtask

  task automatic t_drop();
    logic [31:0] v;
    wr(3'd3, 32'h11);
    wr(3'd3, 32'h22);
    repeat (5) @(posedge clk); #1;
    rd(3'd3, v); chk("R4 dropped write", v, 32'h11);
    rd(3'd5, v); chk("R4 error set", v & 32'h80, 32'h80);
    wr_wait(3'd5, 32'h80);
    rd(3'd5, v); chk("R5 error cleared", v & 32'h80, 0);
    wr_wait(3'd5, 32'h700);
    rd(3'd5, v); chk("R5 handshake bits unaffected", v & 32'h700, 32'h300);
  endtask

  task automatic t_time();
    logic [31:0] v;
    wr_wait(3'd4, 32'h8);
    rd(3'd4, v); chk("R2 control", v, 32'h8);
    ticks(5);
    rd(3'd1, v); chk("R6 frozen unseeded", v, 0);
    wr_wait(3'd1, 32'hFFFF_FFFE);
    ticks(2);
    rd(3'd1, v); chk("R6 subsec write does not start", v, 32'hFFFF_FFFE);
    wr_wait(3'd0, 32'd100);
    ticks(3);
    rd(3'd0, v); chk("R7 wrap carry", v, 32'd101);
    rd(3'd1, v); chk("R7 subsec after wrap", v, 32'd1);
    wr_wait(3'd4, 32'h0);
    ticks(2);
    rd(3'd1, v); chk("R6 stopped by run bit", v, 32'd1);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr_wait(3'd3, 32'd5);
    wr_wait(3'd2, 32'd101);
    wr_wait(3'd4, 32'h8);
    rd(3'd5, v); chk("R8 no early alarm", v & 32'h10, 0);
    ticks(4);
    repeat (2) @(posedge clk); #1;
    rd(3'd5, v); chk("R8 alarm match", v & 32'h10, 32'h10);
    chk("R10 alarm masked", {31'd0, irq}, 0);
    wr_wait(3'd6, 32'h10);
    chk("R10 alarm irq", {31'd0, irq}, 1);
    ticks(1);
    wr_wait(3'd5, 32'h10);
    rd(3'd5, v); chk("R5 alarm cleared", v & 32'h10, 0);
    chk("R10 irq drops", {31'd0, irq}, 0);
  endtask

  task automatic t_unset();
    logic [31:0] v;
    wr_wait(3'd2, 32'hFFFF_FFFF);
    wr_wait(3'd4, 32'h0);
    wr_wait(3'd1, 32'h0);
    wr_wait(3'd0, 32'hFFFF_FFFF);
    wr_wait(3'd3, 32'h0);
    repeat (3) @(posedge clk); #1;
    rd(3'd5, v); chk("R8 unset alarm never matches", v & 32'h10, 0);
  endtask

  task automatic t_viol();
    logic [31:0] v;
    @(negedge clk); sec_viol = 1'b1;
    @(posedge clk); #1; sec_viol = 1'b0;
    rd(3'd5, v); chk("R9 violation and invalid set", v & 32'h3, 32'h3);
    wr_wait(3'd5, 32'h3);
    rd(3'd5, v); chk("R9 R5 both cleared", v & 32'h3, 0);
  endtask

  task automatic t_irq();
    wr_wait(3'd6, 32'h100);
    chk("R10 complete irq", {31'd0, irq}, 1);
    wr_wait(3'd6, 32'h200);
    chk("R10 ready irq", {31'd0, irq}, 1);
    wr(3'd3, 32'h7);
    chk("R10 ready irq low while busy", {31'd0, irq}, 0);
    repeat (5) @(posedge clk); #1;
    chk("R10 ready irq back", {31'd0, irq}, 1);
    wr_wait(3'd6, 32'h0);
    chk("R10 all masked", {31'd0, irq}, 0);
  endtask

  initial begin
    #500_000;
    if (!done_flag) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_handshake();
    t_drop();
    t_time();
    t_alarm();
    t_unset();
    t_viol();
    t_irq();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule